// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit gathers the single-cycle event pulses raised by an I2C bus engine and turns them into sticky status flags, a maskable interrupt line and a readable interrupt vector. Seven sources are tracked: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. The status view also shows two live bus-state inputs, receive shift register full and bus busy. These two are not stored.

A host reaches the unit through a plain 16-bit register port that uses byte offsets. A service routine reads the vector register in a loop. Each read returns the code of the most urgent pending source that is enabled, and the same read clears that source's flag. The routine stops when the vector reads zero. A flag can also be cleared by writing 1 to its bit in the status register. An event that arrives in the same cycle as a clear always wins, so no event is lost.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset every event flag and every mask bit is 0, `irq_o` is low, and reads of the mask and vector registers return 0.
- R2: A one-cycle pulse on an event input sets a sticky flag that is visible on the next cycle in the status register (offset 0x08) at bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 5 stop detected, bit 6 addressed-as-slave.
- R3: Status bit 11 shows `rx_full_i` and status bit 12 shows `bus_busy_i` in the same cycle. Status bits 7 to 10 and 13 to 15 read 0, and writes have no effect on bits 11 and 12.
- R4: The mask register (offset 0x04) stores bits 6:0 in the same bit order as the status flags. It reads back what was written, and its bits 15:7 read 0.
- R5: The vector register (offset 0x28) returns, in bits 2:0, the code of the lowest-numbered pending unmasked flag. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed-as-slave. It returns 0 when no enabled flag is pending.
- R6: A read of the vector register (`rd_en_i` high) clears, at the next clock edge, only the flag whose code it returned.
- R7: Writing the status register clears each of flags 6:0 whose data bit is 1 and leaves the other flags alone.
- R8: `irq_o` is high exactly while at least one flag is set whose mask bit is also set.
- R9: If an event pulse lands in the same cycle as a clear of its flag (by a vector read or a status write), the flag stays set.
- R10: Masked flags still appear in the status register, but they neither drive `irq_o` nor appear in the vector.
- R11: Reads of any other offset return 0, and writes to any other offset change neither the mask nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_arb_lost_i | input | 1 | Arbitration-lost event pulse |
| ev_nack_i | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy_i | input | 1 | Access-ready event pulse |
| ev_rx_rdy_i | input | 1 | Receive-ready event pulse |
| ev_tx_rdy_i | input | 1 | Transmit-ready event pulse |
| ev_stop_i | input | 1 | Stop-detected event pulse |
| ev_slave_i | input | 1 | Addressed-as-slave event pulse |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_full_i | input | 1 | Live receive-shift-full level |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (needed for the vector's clear-on-read) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never raises `rd_en_i` and `wr_en_i` together, and that each strobe addresses a single register for one cycle. The bench drives every access through one task that asserts at most one strobe per cycle, so the stimulus stays within that assumption. Event pulses may come at any time and in any combination. Random stimulus deliberately lets them coincide with vector reads and status writes, which exercises the set-wins rule. The live bus levels change freely between accesses.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_EV      = 7;
    localparam int EV_ARB      = 0;
    localparam int EV_NACK     = 1;
    localparam int EV_ACC      = 2;
    localparam int EV_RX       = 3;
    localparam int EV_TX       = 4;
    localparam int EV_STOP     = 5;
    localparam int EV_SLAVE    = 6;
    localparam int STAT_RSF    = 11;
    localparam int STAT_BB     = 12;
    localparam logic [7:0] OFS_MASK = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_VEC  = 8'h28;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
    parameter int NUM_EV = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] set_i,
    input  logic [NUM_EV-1:0] clr_i,
    output logic [NUM_EV-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_EV-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EV; i++) begin
            // a pulse in the clearing cycle keeps the flag
            st_d.flags[i] = set_i[i] | (st_q.flags[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R9
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
    parameter int NUM_EV = 7,
    parameter int CODE_W = 3
) (
    input  logic [NUM_EV-1:0] req_i,
    output logic [NUM_EV-1:0] grant_o,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        grant_o = '0;
        code_o  = '0;
        // scan downward so the lowest index is the last to overwrite
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                code_o     = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NUM_EV = 7,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_EV-1:0] flags_i,
    input  logic [NUM_EV-1:0] grant_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              rsf_i,
    input  logic              bb_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_EV-1:0] mask_o,
    output logic [NUM_EV-1:0] clr_o
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

    typedef struct packed {
        logic [NUM_EV-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit_mask, hit_stat, hit_vec;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = &{1'b0, wdata_i[DATA_W-1:NUM_EV]};

    always_comb begin
        hit_mask = (addr_i == A_MASK);
        hit_stat = (addr_i == A_STAT);
        hit_vec  = (addr_i == A_VEC);

        st_d = st_q;
        if (wr_en_i && hit_mask) st_d.mask = wdata_i[NUM_EV-1:0];

        clr_o = '0;
        if (wr_en_i && hit_stat) clr_o = clr_o | wdata_i[NUM_EV-1:0];
        if (rd_en_i && hit_vec)  clr_o = clr_o | grant_i;

        rdata_o = '0;
        if (hit_mask) rdata_o[NUM_EV-1:0] = st_q.mask;
        if (hit_stat) begin
            rdata_o[NUM_EV-1:0] = flags_i;
            rdata_o[STAT_RSF]   = rsf_i;
            rdata_o[STAT_BB]    = bb_i;
        end
        if (hit_vec) rdata_o[CODE_W-1:0] = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && hit_mask) |=> $stable(mask_o)); // R11
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost_i,
    input  logic              ev_nack_i,
    input  logic              ev_acc_rdy_i,
    input  logic              ev_rx_rdy_i,
    input  logic              ev_tx_rdy_i,
    input  logic              ev_stop_i,
    input  logic              ev_slave_i,
    input  logic              bus_busy_i,
    input  logic              rx_full_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CODE_W = $clog2(NUM_EV + 1);

    ev_vec_t             evts, flags_q, mask_q, pending, grant, clr;
    logic [CODE_W-1:0]   vec_code;

    always_comb begin
        evts           = '0;
        evts[EV_ARB]   = ev_arb_lost_i;
        evts[EV_NACK]  = ev_nack_i;
        evts[EV_ACC]   = ev_acc_rdy_i;
        evts[EV_RX]    = ev_rx_rdy_i;
        evts[EV_TX]    = ev_tx_rdy_i;
        evts[EV_STOP]  = ev_stop_i;
        evts[EV_SLAVE] = ev_slave_i;
        pending        = flags_q & mask_q;
        irq_o          = |pending;
    end

    i2c_irq_flags #(.NUM_EV(NUM_EV)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evts),
        .clr_i   (clr),
        .flags_o (flags_q)
    );

    i2c_irq_prio #(.NUM_EV(NUM_EV), .CODE_W(CODE_W)) u_prio (
        .req_i   (pending),
        .grant_o (grant),
        .code_o  (vec_code)
    );

    i2c_irq_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EV(NUM_EV), .CODE_W(CODE_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .wdata_i (wdata_i),
        .flags_i (flags_q),
        .grant_i (grant),
        .code_i  (vec_code),
        .rsf_i   (rx_full_i),
        .bb_i    (bus_busy_i),
        .rdata_o (rdata_o),
        .mask_o  (mask_q),
        .clr_o   (clr)
    );

    AST_IRQ_VS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_code != '0)); // R8
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5
    AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(OFS_VEC) && (|grant) && ((grant & evts) == '0))
        |=> ((flags_q & $past(grant)) == '0)); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_STAT))
        |=> ((flags_q & $past(wdata_i[NUM_EV-1:0] & ~evts)) == '0)); // R7
endmodule

// File: tb/i2c_irq_unit_tb.sv
module i2c_irq_unit_tb;
    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev = '0;
    logic        bb = 1'b0, rf = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0] m_flags = '0;
    logic [6:0] m_mask  = '0;

    always #5 clk = ~clk;

    i2c_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_lost_i(ev[0]), .ev_nack_i(ev[1]), .ev_acc_rdy_i(ev[2]),
        .ev_rx_rdy_i(ev[3]), .ev_tx_rdy_i(ev[4]), .ev_stop_i(ev[5]),
        .ev_slave_i(ev[6]), .bus_busy_i(bb), .rx_full_i(rf),
        .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [2:0] exp_vec();
        logic [6:0] p = m_flags & m_mask;
        for (int i = 0; i < 7; i++) if (p[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        case (a)
            A_MASK:  return {9'd0, m_mask};
            A_STAT:  return {3'd0, bb, rf, 4'd0, m_flags};
            A_VEC:   return {13'd0, exp_vec()};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // one clock of host/engine activity; at most one strobe
    task automatic step(input logic [6:0] e, input bit w, input bit r,
                        input logic [7:0] a, input logic [15:0] d,
                        input logic [1:0] lv, input string tag);
        logic [6:0] clr;
        string t;
        @(negedge clk);
        ev = e; wr = w; rd = r; addr = a; wdata = d; bb = lv[1]; rf = lv[0];
        #1;
        chk((tag != "") ? tag : "R8 irq", {15'd0, irq}, {15'd0, |(m_flags & m_mask)});
        if (r) begin
            if (tag != "") t = tag;
            else if (a == A_STAT) t = "R2 status";
            else if (a == A_MASK) t = "R4 mask";
            else if (a == A_VEC)  t = "R5 vector";
            else                  t = "R11 unmapped";
            chk(t, rdata, exp_read(a));
        end
        clr = '0;
        if (w && a == A_STAT) clr = d[6:0];
        if (r && a == A_VEC && exp_vec() != 0) clr[exp_vec() - 1] = 1'b1;
        if (w && a == A_MASK) m_mask = d[6:0];
        m_flags = (m_flags & ~clr) | e;
        @(posedge clk);
    endtask

    task automatic idle();
        step('0, 0, 0, 8'h00, 16'h0, {bb, rf}, "");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        step('0, 0, 1, A_MASK, 0, 2'b00, "R1 mask");
        step('0, 0, 1, A_VEC,  0, 2'b00, "R1 vector");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R1 status");

        // R3: live levels, writes do not touch them
        step('0, 0, 1, A_STAT, 0, 2'b10, "R3 busy");
        step('0, 0, 1, A_STAT, 0, 2'b01, "R3 rsfull");
        step('0, 1, 0, A_STAT, 16'hFFFF, 2'b01, "R3 write");
        step('0, 0, 1, A_STAT, 0, 2'b01, "R3 after write");

        // R10: masked events visible in status only
        step(7'h7F, 0, 0, 0, 0, 2'b00, "");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R10 status");
        step('0, 0, 1, A_VEC,  0, 2'b00, "R10 vector");

        // R5/R6: enable all, drain vector in priority order down to zero
        step('0, 1, 0, A_MASK, 16'hFF7F, 2'b00, "");
        step('0, 0, 1, A_MASK, 0, 2'b00, "R4 upper zero");
        for (int i = 0; i < 8; i++) step('0, 0, 1, A_VEC, 0, 2'b00, "R6 drain");

        // R9: event coincides with vector-read clear
        step(7'h01, 0, 0, 0, 0, 2'b00, "");
        step(7'h01, 0, 1, A_VEC, 0, 2'b00, "R9 vector");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R9 status kept");

        // R7: selective write-1-to-clear
        step(7'h7F, 0, 0, 0, 0, 2'b00, "");
        step('0, 1, 0, A_STAT, 16'h0024, 2'b00, "");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R7 status");
        step(7'h02, 1, 0, A_STAT, 16'h0002, 2'b00, "");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R9 w1c kept");

        // R11: unmapped offset
        step('0, 1, 0, 8'h0C, 16'hFFFF, 2'b00, "");
        step('0, 0, 1, A_MASK, 0, 2'b00, "R11 mask kept");
        step('0, 0, 1, A_STAT, 0, 2'b00, "R11 flags kept");
        step('0, 0, 1, 8'h0C,  0, 2'b11, "R11 read zero");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [6:0] e;
            logic [7:0] a;
            int op;
            e  = (($urandom % 4) == 0) ? 7'($urandom) : 7'd0;
            op = $urandom % 7;
            case (op)
                0: a = A_STAT; 1: a = A_MASK; 2, 3: a = A_VEC;
                default: a = (($urandom % 3) == 0) ? 8'($urandom) : A_STAT;
            endcase
            if (op == 5 || op == 6)
                step(e, 1, 0, (op == 6) ? A_MASK : a, 16'($urandom), 2'($urandom), "");
            else
                step(e, 0, (op != 4) || (($urandom % 2) == 0), a, 0, 2'($urandom), "");
        end
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule